// File: doc/BRIEF.md
# Spread-Spectrum Sweep Offset Generator

This block is the digital part of a spread-spectrum clock source. Each cycle it produces a signed frequency-offset word that steers a digitally controlled oscillator or a fractional divider. The word traces a slow symmetric triangle between two bounds, so the steered clock sweeps across a narrow band. This spreads the energy of the fundamental and its harmonics and lowers peak emissions. The offset is an integer in sixteenths of one percent of the nominal frequency, so every bound is an exact integer.

A three-bit select chooses the sweep. The top bit picks a band that lies entirely below nominal or a band centred on nominal. The two low bits pick one of four total spans, from 1.25% to 10%. The sweep rate is set so that one full triangle lasts about a thousand output clocks. An active-low enable switches modulation on. A stop input drives both clock enables low, one for the modulated output and one for a reference output that is never modulated.

Top module: `sweep_offset_gen`

## Requirements
- R1: With `mod_sel[2]`=0, the sweep runs between an upper bound of 0 and a lower bound of -20, -40, -80 or -160 units (1 unit = 1/16 %) for `mod_sel[1:0]` = 0, 1, 2, 3. Both bounds are reached.
- R2: With `mod_sel[2]`=1, the sweep runs between ±10, ±20, ±40 or ±80 units for `mod_sel[1:0]` = 0, 1, 2, 3. Both bounds are reached.
- R3: While `spread_en_n` is high, or after reset, `offset` is 0.
- R4: One cycle after `stop` is sampled high, `offset` is 0 and both `mod_clk_en` and `ref_clk_en` are low.
- R5: `ref_clk_en` is the registered inverse of `stop` and does not depend on `spread_en_n`.
- R6: An accumulator adds twice the active span every cycle. One step is taken in each cycle in which it reaches `PERIOD_CYC`, so a full triangle lasts exactly `PERIOD_CYC` cycles.
- R7: Each step moves `offset` by exactly one unit. Direction reverses when a step falls due while `offset` sits on the bound it is heading to, and `offset` never leaves the active bounds.
- R8: A change of `mod_sel` takes effect only at such a reversal. If it differs from the active selection there, `offset` jumps to the new upper bound and heads down.
- R9: In the first cycle after modulation becomes enabled (`spread_en_n` low and `stop` low), `offset` equals the upper bound of `mod_sel`, the direction is down, and the accumulator is zero.
- R10: `at_bound` is high exactly when the sweep is running and `offset` equals the active upper or lower bound.
- R11: For a down-spread selection, the mean of `offset` over one period equals the upper bound minus half the span, to within one unit.
- R12: `mod_clk_en` is the registered inverse of `stop`, and it is low in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spread_en_n | input | 1 | Modulation enable, active low |
| mod_sel | input | 3 | Bit 2: centred band; bits 1:0: span code |
| stop | input | 1 | Forces both clock enables low and the offset to nominal |
| offset | output | OFS_W | Signed offset in 1/16 % of nominal |
| at_bound | output | 1 | Offset sits on an active bound |
| mod_clk_en | output | 1 | Enable for the modulated clock |
| ref_clk_en | output | 1 | Enable for the unmodulated reference clock |

## Verification
The bench builds the block with its defaults, `PERIOD_CYC`=1000 and `OFS_W`=10. At these values all eight selections can be swept for two full periods each, so each period can be measured between arrivals at the upper bound, and the mean can be taken over one whole down-spread triangle. The 10% span needs 320 steps per period, which tests the accumulator's uneven step spacing. The 1.25% span steps every 25 cycles exactly. A switch from the widest down band to the narrowest centred band while the ramp is partway down shows that the offset stays outside the new bounds until the lower reversal.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    // width of the sweep selection field: centred flag plus two span bits
    localparam int SEL_W = 3;

    // narrowest total span: 1.25 % expressed in 1/16 % units
    localparam int BASE_SPAN = 20;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SWEEP = 1'b1
    } state_e;

    typedef struct packed {
        state_e           st;
        dir_e             dir;
        logic [SEL_W-1:0] cfg;
    } ctl_t;

    // total span of a selection, doubling with each span code step
    function automatic int span_of(input int code);
        return BASE_SPAN << (code & 3);
    endfunction

    // upper bound: nominal for down spread, half the span for centred spread
    function automatic int upper_of(input int code);
        return (((code >> 2) & 1) != 0) ? span_of(code) / 2 : 0;
    endfunction

    function automatic int lower_of(input int code);
        return upper_of(code) - span_of(code);
    endfunction

endpackage

// File: rtl/sweep_bound.sv
module sweep_bound
    import sweep_pkg::*;
#(
    parameter int OFS_W = 10,
    parameter bit LOWER = 1'b0
) (
    input  logic [SEL_W-1:0]        sel,
    output logic signed [OFS_W-1:0] bound
);

    localparam int N_CODES = 1 << SEL_W;

    logic signed [OFS_W-1:0] tbl [N_CODES];

    for (genvar c = 0; c < N_CODES; c++) begin : g_code
        if (LOWER) begin : g_lo
            assign tbl[c] = OFS_W'(lower_of(c));
        end else begin : g_hi
            assign tbl[c] = OFS_W'(upper_of(c));
        end
    end

    assign bound = tbl[sel];

endmodule

// File: rtl/sweep_pacer.sv
module sweep_pacer #(
    parameter int PERIOD_CYC = 1000,
    parameter int ACC_W      = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [ACC_W-1:0] inc,
    output logic             tick
);

    localparam logic [ACC_W-1:0] PER = ACC_W'(PERIOD_CYC);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum;

    always_comb begin
        sum  = acc_q + inc;
        tick = !clr && (sum >= PER);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (tick) begin
            acc_q <= sum - PER;
        end else begin
            acc_q <= sum;
        end
    end

    // R6: the fractional remainder always stays below one period
    p_acc_below_period_r6: assert property (@(posedge clk) disable iff (rst)
        acc_q < PER);

    // R6: a cleared pacer starts the next cycle from zero
    p_clear_zeroes_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_q == '0));

endmodule

// File: rtl/sweep_core.sv
module sweep_core
    import sweep_pkg::*;
#(
    parameter int OFS_W = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    tick,
    input  logic [SEL_W-1:0]        sel_in,
    input  logic signed [OFS_W-1:0] hi_cur,
    input  logic signed [OFS_W-1:0] lo_cur,
    input  logic signed [OFS_W-1:0] hi_new,
    output logic [SEL_W-1:0]        cfg_o,
    output logic signed [OFS_W-1:0] off_o,
    output logic                    at_edge_o,
    output logic                    pace_clr_o
);

    localparam logic signed [OFS_W-1:0] ONE = OFS_W'(1);

    ctl_t                    ctl_q, ctl_d;
    logic signed [OFS_W-1:0] off_q, off_d;
    logic                    on_hi, on_lo, turn;

    always_comb begin
        on_hi = (off_q == hi_cur);
        on_lo = (off_q == lo_cur);
        turn  = ((ctl_q.dir == DIR_DOWN) && on_lo) ||
                ((ctl_q.dir == DIR_UP) && on_hi);
    end

    always_comb begin
        ctl_d = ctl_q;
        off_d = off_q;
        if (!en) begin
            ctl_d.st  = ST_IDLE;
            ctl_d.dir = DIR_DOWN;
            ctl_d.cfg = sel_in;
            off_d     = '0;
        end else if (ctl_q.st == ST_IDLE) begin
            ctl_d.st  = ST_SWEEP;
            ctl_d.dir = DIR_DOWN;
            ctl_d.cfg = sel_in;
            off_d     = hi_new;
        end else if (tick) begin
            if (turn && (sel_in != ctl_q.cfg)) begin
                ctl_d.cfg = sel_in;
                ctl_d.dir = DIR_DOWN;
                off_d     = hi_new;
            end else if (turn) begin
                ctl_d.dir = (ctl_q.dir == DIR_DOWN) ? DIR_UP : DIR_DOWN;
                off_d     = (ctl_q.dir == DIR_DOWN) ? off_q + ONE : off_q - ONE;
            end else begin
                off_d     = (ctl_q.dir == DIR_DOWN) ? off_q - ONE : off_q + ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '{st: ST_IDLE, dir: DIR_DOWN, cfg: '0};
            off_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            off_q <= off_d;
        end
    end

    assign cfg_o      = ctl_q.cfg;
    assign off_o      = off_q;
    assign at_edge_o  = (ctl_q.st == ST_SWEEP) && (on_hi || on_lo);
    assign pace_clr_o = !en || (ctl_q.st == ST_IDLE);

    // R7: a running sweep stays inside its active bounds
    p_within_bounds_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.st == ST_SWEEP) |-> ((off_q <= hi_cur) && (off_q >= lo_cur)));

    // R7: with the selection unchanged, a step moves exactly one unit
    p_single_unit_r7: assert property (@(posedge clk) disable iff (rst)
        ((ctl_q.st == ST_SWEEP) && en && tick && (sel_in == ctl_q.cfg))
        |=> ((off_q == $past(off_q) + ONE) || (off_q == $past(off_q) - ONE)));

    // R6: no step is taken without a pacer tick
    p_hold_between_ticks_r6: assert property (@(posedge clk) disable iff (rst)
        ((ctl_q.st == ST_SWEEP) && en && !tick) |=> $stable(off_q));

    // R3: disabled modulation leaves the offset at nominal
    p_nominal_when_off_r3: assert property (@(posedge clk) disable iff (rst)
        !en |=> (off_q == '0));

    // R9: enabling starts at the upper bound heading down
    p_start_at_top_r9: assert property (@(posedge clk) disable iff (rst)
        ((ctl_q.st == ST_IDLE) && en) |=> ((off_q == hi_cur) && (ctl_q.dir == DIR_DOWN)));

    // R8: the active selection changes only at a reversal
    p_cfg_only_at_turn_r8: assert property (@(posedge clk) disable iff (rst)
        ((ctl_q.st == ST_SWEEP) && en && !(tick && turn)) |=> $stable(ctl_q.cfg));

endmodule

// File: rtl/sweep_gate.sv
module sweep_gate (
    input  logic clk,
    input  logic rst,
    input  logic stop,
    output logic mod_en,
    output logic ref_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mod_en <= 1'b0;
            ref_en <= 1'b0;
        end else begin
            mod_en <= !stop;
            ref_en <= !stop;
        end
    end

    // R4: stop pulls both enables low on the next cycle
    p_stop_gates_r4: assert property (@(posedge clk) disable iff (rst)
        stop |=> (!mod_en && !ref_en));

    // R5: the reference enable returns as soon as stop is released
    p_ref_follows_r5: assert property (@(posedge clk) disable iff (rst)
        !stop |=> ref_en);

    // R12: the modulated enable follows stop as well
    p_mod_follows_r12: assert property (@(posedge clk) disable iff (rst)
        !stop |=> mod_en);

endmodule

// File: rtl/sweep_offset_gen.sv
module sweep_offset_gen
    import sweep_pkg::*;
#(
    parameter int PERIOD_CYC = 1000,
    parameter int OFS_W      = 10
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    spread_en_n,
    input  logic [SEL_W-1:0]        mod_sel,
    input  logic                    stop,
    output logic signed [OFS_W-1:0] offset,
    output logic                    at_bound,
    output logic                    mod_clk_en,
    output logic                    ref_clk_en
);

    localparam int ACC_W = $clog2(PERIOD_CYC) + 2;

    logic                    run_en;
    logic                    tick;
    logic                    pace_clr;
    logic [SEL_W-1:0]        cfg;
    logic signed [OFS_W-1:0] hi_cur, lo_cur, hi_new;
    logic [ACC_W-1:0]        inc;

    assign run_en = !spread_en_n && !stop;
    assign inc    = ACC_W'($unsigned(hi_cur - lo_cur)) << 1;

    sweep_bound #(.OFS_W(OFS_W), .LOWER(1'b0)) u_hi_cur (
        .sel   (cfg),
        .bound (hi_cur)
    );

    sweep_bound #(.OFS_W(OFS_W), .LOWER(1'b1)) u_lo_cur (
        .sel   (cfg),
        .bound (lo_cur)
    );

    sweep_bound #(.OFS_W(OFS_W), .LOWER(1'b0)) u_hi_new (
        .sel   (mod_sel),
        .bound (hi_new)
    );

    sweep_pacer #(.PERIOD_CYC(PERIOD_CYC), .ACC_W(ACC_W)) u_pacer (
        .clk  (clk),
        .rst  (rst),
        .clr  (pace_clr),
        .inc  (inc),
        .tick (tick)
    );

    sweep_core #(.OFS_W(OFS_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .en         (run_en),
        .tick       (tick),
        .sel_in     (mod_sel),
        .hi_cur     (hi_cur),
        .lo_cur     (lo_cur),
        .hi_new     (hi_new),
        .cfg_o      (cfg),
        .off_o      (offset),
        .at_edge_o  (at_bound),
        .pace_clr_o (pace_clr)
    );

    sweep_gate u_gate (
        .clk    (clk),
        .rst    (rst),
        .stop   (stop),
        .mod_en (mod_clk_en),
        .ref_en (ref_clk_en)
    );

endmodule

// File: tb/sweep_offset_gen_test.sv
`timescale 1ns/1ps
module sweep_offset_gen_test;

    localparam int P  = 1000;
    localparam int OW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          spn = 1'b1;
    logic          stop = 1'b0;
    logic [2:0]    sel = 3'd0;
    logic signed [OW-1:0] off;
    logic          flag, men, ren;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;
    bit  cmp_on = 1'b0;

    always #2 clk = ~clk;

    sweep_offset_gen #(.PERIOD_CYC(P), .OFS_W(OW)) uut (
        .clk         (clk),
        .rst         (rst),
        .spread_en_n (spn),
        .mod_sel     (sel),
        .stop        (stop),
        .offset      (off),
        .at_bound    (flag),
        .mod_clk_en  (men),
        .ref_clk_en  (ren)
    );

    // bounds straight from R1 and R2
    function automatic int exp_hi(input int c);
        case (c)
            4: return 10;
            5: return 20;
            6: return 40;
            7: return 80;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_lo(input int c);
        case (c)
            0: return -20;
            1: return -40;
            2: return -80;
            3: return -160;
            4: return -10;
            5: return -20;
            6: return -40;
            default: return -80;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference model
    int m_off = 0, m_acc = 0, m_dir = 0, m_cfg = 0;
    bit m_sweep = 1'b0, m_men = 1'b0, m_ren = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_sweep = 0; m_off = 0; m_acc = 0; m_dir = 0; m_cfg = 0;
            m_men = 0; m_ren = 0;
        end else begin
            m_men = !stop;
            m_ren = !stop;
            if (spn || stop) begin
                m_sweep = 0; m_off = 0; m_acc = 0; m_dir = 0; m_cfg = int'(sel);
            end else if (!m_sweep) begin
                m_sweep = 1; m_cfg = int'(sel); m_off = exp_hi(m_cfg);
                m_dir = 0; m_acc = 0;
            end else begin
                int s;
                bit at;
                s = m_acc + 2 * (exp_hi(m_cfg) - exp_lo(m_cfg));
                if (s >= P) begin
                    m_acc = s - P;
                    at = (m_dir == 0 && m_off == exp_lo(m_cfg)) ||
                         (m_dir == 1 && m_off == exp_hi(m_cfg));
                    if (at && int'(sel) != m_cfg) begin
                        m_cfg = int'(sel); m_off = exp_hi(m_cfg); m_dir = 0;
                    end else begin
                        if (at) m_dir = 1 - m_dir;
                        m_off = m_off + ((m_dir == 1) ? 1 : -1);
                    end
                end else begin
                    m_acc = s;
                end
            end
        end
    end

    // compare against the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            bit ef;
            ef = m_sweep && (m_off == exp_hi(m_cfg) || m_off == exp_lo(m_cfg));
            check(int'(off) == m_off, "R7", "offset vs model", int'(off), m_off);
            check(flag == ef, "R10", "at_bound vs model", int'(flag), int'(ef));
            check(men == m_men, "R12", "mod_clk_en vs model", int'(men), int'(m_men));
            check(ren == m_ren, "R5", "ref_clk_en vs model", int'(ren), int'(m_ren));
        end
    end

    task automatic summary_and_end();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
            summary_and_end();
        end
    end

    initial begin
        @(negedge clk);
        cmp_on = 1'b1;
        repeat (2) @(negedge clk);
        // reset state
        check(int'(off) == 0, "R3", "reset offset", int'(off), 0);
        check(men == 1'b0, "R12", "reset mod_clk_en", int'(men), 0);
        check(flag == 1'b0, "R10", "reset at_bound", int'(flag), 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // spread disabled, not stopped: reference and modulated enables on, offset nominal
        check(ren == 1'b1, "R5", "ref enable with spread off", int'(ren), 1);
        check(men == 1'b1, "R12", "mod enable with spread off", int'(men), 1);
        check(int'(off) == 0, "R3", "offset with spread off", int'(off), 0);

        for (int c = 0; c < 8; c++) begin
            int hi, lo, mn, mx, prev, sum, a0, a1, na;
            hi = exp_hi(c);
            lo = exp_lo(c);
            spn = 1'b1;
            sel = 3'(c);
            repeat (3) @(negedge clk);
            check(int'(off) == 0, "R3", "offset while disabled", int'(off), 0);
            check(flag == 1'b0, "R10", "at_bound while disabled", int'(flag), 0);
            spn = 1'b0;
            @(negedge clk);
            check(int'(off) == hi, "R9", "offset after enable", int'(off), hi);
            check(flag == 1'b1, "R10", "at_bound at start", int'(flag), 1);
            mn = int'(off); mx = int'(off); prev = int'(off);
            sum = int'(off); a0 = -1; a1 = -1; na = 0;
            for (int n = 2; n <= 2 * P + 20; n++) begin
                int cur;
                @(negedge clk);
                cur = int'(off);
                if (cur < mn) mn = cur;
                if (cur > mx) mx = cur;
                if (n <= P) sum += cur;
                if (cur == hi && prev != hi) begin
                    if (na == 0) a0 = n;
                    else if (na == 1) a1 = n;
                    na++;
                end
                prev = cur;
            end
            if (c < 4) begin
                check(mn == lo, "R1", "down-spread minimum", mn, lo);
                check(mx == hi, "R1", "down-spread maximum", mx, hi);
                check((2 * sum - (hi + lo) * P) <= 2 * P && (2 * sum - (hi + lo) * P) >= -2 * P,
                      "R11", "down-spread mean x2P", 2 * sum, (hi + lo) * P);
            end else begin
                check(mn == lo, "R2", "centre-spread minimum", mn, lo);
                check(mx == hi, "R2", "centre-spread maximum", mx, hi);
            end
            check(na >= 2 && (a1 - a0) == P, "R6", "period in cycles", a1 - a0, P);
        end

        // selection change mid-ramp waits for a reversal
        spn = 1'b1;
        sel = 3'd3;
        repeat (2) @(negedge clk);
        spn = 1'b0;
        repeat (100) @(negedge clk);
        sel = 3'd4;
        repeat (5) @(negedge clk);
        check(int'(off) < -10, "R8", "offset still on old ramp", int'(off), -11);
        repeat (600) @(negedge clk);
        check(int'(off) <= 10 && int'(off) >= -10, "R8", "offset inside new bounds",
              int'(off), 0);

        // stop while sweeping, then release
        stop = 1'b1;
        @(negedge clk);
        check(int'(off) == 0, "R4", "offset while stopped", int'(off), 0);
        check(men == 1'b0, "R4", "mod_clk_en while stopped", int'(men), 0);
        check(ren == 1'b0, "R4", "ref_clk_en while stopped", int'(ren), 0);
        repeat (3) @(negedge clk);
        stop = 1'b0;
        @(negedge clk);
        check(int'(off) == 10, "R9", "restart after stop", int'(off), 10);
        check(men == 1'b1, "R12", "mod_clk_en after stop", int'(men), 1);
        check(ren == 1'b1, "R5", "ref_clk_en after stop", int'(ren), 1);
        repeat (50) @(negedge clk);

        summary_and_end();
    end

endmodule